// File: doc/BRIEF.md
# Double-Buffered SPI Master Transmitter

This block is a transmit-only SPI master. It has two stages. A one-word holding register takes writes from the host. A shift register drives the serial clock and data pins. The host writes a word whenever `tx_empty` is high. As soon as the shifter is idle, the word moves into it, `tx_empty` rises again, and the bits go out most significant first in mode 0. The serial clock idles low and the receiver samples on the rising edge.

The two status outputs answer different questions. `tx_empty` says only that the holding register can take another word. Because an idle shifter takes the word on the very next cycle, `tx_empty` may be low for a single clock. `busy` stays high until the last bit has left the pins, so a host that must know a transfer is finished waits for `busy` to fall. If the host writes while the holding register is full, the write is dropped and a sticky overrun flag is raised. The flag stays set until the host clears it.

The shifter is a three-state machine. `ST_IDLE` is the idle state: `sck` is low, `mosi` is low and `busy` is low. `ST_SCK_LOW` is the first half of a bit, with `sck` low and the bit presented on `mosi`. `ST_SCK_HIGH` is the second half of a bit, with `sck` high. The transitions are as follows:
- idle to low (`load`): taken when the holding register is full.
- low to high (`rise`): taken after half an SCK period.
- high to low (`next`): taken after half a period while bits remain.
- high to low (`reload`): taken after the last bit when another word is waiting.
- high to idle (`done`): taken after the last bit when the holding register is empty.

Top module: `spi_tx_dbuf`

## Requirements
- R1: After reset, `tx_empty` is 1 and `busy`, `sck`, `mosi` and `ovr_flag` are all 0.
- R2: A write (`wr_en` high) while `tx_empty` is 1 captures `wr_data`, and `tx_empty` reads 0 in the next cycle.
- R3: An idle shifter takes a waiting word one cycle after it is written. In that same cycle `tx_empty` returns to 1 and `busy` rises, so `tx_empty` is low for exactly one cycle.
- R4: `busy` stays high until the last bit has been shifted out. For one word with no successor it is high for exactly 8 × CLK_DIV system cycles, which is 256 with the default values.
- R5: Each word is 8 bits and is sent most significant bit first. The value sampled on `mosi` at the rising edges of `sck` equals the written word.
- R6: The `sck` period is CLK_DIV system clocks (32 by default) with equal low and high halves. Rising edges within a word are exactly CLK_DIV cycles apart.
- R7: Mode 0 timing applies. `sck` idles low, `mosi` is presented half a period before each rising edge, and `mosi` does not change while `sck` is high.
- R8: A write while `tx_empty` is 0 is ignored and sets `ovr_flag`. The flag stays set until `ovr_clr` is pulsed. A new overrun in the same cycle as a clear wins over the clear.
- R9: When a word finishes and the holding register is full, the next word is loaded at once. The gap between the last rising edge of one word and the first of the next is exactly CLK_DIV cycles, and `busy` stays high across the boundary.
- R10: `sck` is high only while `busy` is high. Whenever `busy` is low, `sck` and `mosi` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Word to transmit (WORD_W bits) |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| tx_empty | output | 1 | Holding register can accept a word |
| busy | output | 1 | A serial transfer is in progress |
| ovr_flag | output | 1 | Sticky flag for a write that was dropped |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out, MSB first |

## Verification
The bench builds the block with its default values, WORD_W = 8 and CLK_DIV = 32. Each word therefore takes 256 system cycles, and each bit half lasts 16 cycles. These sizes let the bench check the exact `busy` length, the spacing of rising edges, and the word boundary in a back-to-back pair in a few thousand cycles. The holding register is full for a long time while a word is shifting, which gives the bench an easy window to try a dropped write. It then confirms that the dropped word never reaches `mosi` and that the holding register is still empty afterwards.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;

    // Shifter states: idle, first half of a bit (sck low), second half (sck high)
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SCK_LOW  = 2'd1,
        ST_SCK_HIGH = 2'd2
    } shift_state_t;

endpackage

// File: rtl/spi_tx_holding.sv
module spi_tx_holding #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    input  logic              ovr_clr,
    output logic              hold_full,
    output logic [WORD_W-1:0] hold_word,
    output logic              ovr_flag
);

    logic wr_accept;
    logic wr_reject;

    assign wr_accept = wr_en & ~hold_full;
    assign wr_reject = wr_en &  hold_full;

    // Occupancy: the shifter taking the word has priority. A write cannot
    // be accepted in that cycle anyway, because the register is full then.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
        end else if (take) begin
            hold_full <= 1'b0;
        end else if (wr_accept) begin
            hold_full <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word <= '0;
        end else if (wr_accept) begin
            hold_word <= wr_data;
        end
    end

    // Sticky overrun: a new rejected write wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
        end else if (wr_reject) begin
            ovr_flag <= 1'b1;
        end else if (ovr_clr) begin
            ovr_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_tx_clkgen.sv
module spi_tx_clkgen #(
    parameter int CLK_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_tick
);

    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;

    assign half_tick = run && (cnt == LAST);

    // The counter is held at zero while idle, so every transfer starts with
    // a full half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || half_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter
    import spi_tx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_full,
    input  logic [WORD_W-1:0] hold_word,
    input  logic              half_tick,
    output logic              take,
    output logic              run,
    output logic              busy,
    output logic              sck,
    output logic              mosi
);

    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    shift_state_t     st_q, st_d;
    logic [WORD_W-1:0] shreg;
    logic [BIT_W-1:0]  bitcnt;
    logic              last_bit;

    assign last_bit = (bitcnt == LAST_BIT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic and load decision
    always_comb begin
        st_d = st_q;
        take = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (hold_full) begin            // load
                    st_d = ST_SCK_LOW;
                    take = 1'b1;
                end
            end
            ST_SCK_LOW: begin
                if (half_tick) begin            // rise
                    st_d = ST_SCK_HIGH;
                end
            end
            ST_SCK_HIGH: begin
                if (half_tick) begin
                    if (!last_bit) begin        // next
                        st_d = ST_SCK_LOW;
                    end else if (hold_full) begin // reload
                        st_d = ST_SCK_LOW;
                        take = 1'b1;
                    end else begin              // done
                        st_d = ST_IDLE;
                    end
                end
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // Shift datapath: load on take, shift on the falling edge of sck
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
        end else if (take) begin
            shreg  <= hold_word;
            bitcnt <= '0;
        end else if (st_q == ST_SCK_HIGH && half_tick) begin
            shreg  <= {shreg[WORD_W-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        busy = 1'b0;
        sck  = 1'b0;
        unique case (st_q)
            ST_IDLE:     begin busy = 1'b0; sck = 1'b0; end
            ST_SCK_LOW:  begin busy = 1'b1; sck = 1'b0; end
            ST_SCK_HIGH: begin busy = 1'b1; sck = 1'b1; end
            default:     begin busy = 1'b0; sck = 1'b0; end
        endcase
        run  = busy;
        mosi = busy & shreg[WORD_W-1];
    end

endmodule

// File: rtl/spi_tx_dbuf.sv
module spi_tx_dbuf #(
    parameter int WORD_W  = 8,
    parameter int CLK_DIV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ovr_clr,
    output logic              tx_empty,
    output logic              busy,
    output logic              ovr_flag,
    output logic              sck,
    output logic              mosi
);

    logic              hold_full;
    logic [WORD_W-1:0] hold_word;
    logic              take;
    logic              run;
    logic              half_tick;

    spi_tx_holding #(.WORD_W(WORD_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .ovr_clr   (ovr_clr),
        .hold_full (hold_full),
        .hold_word (hold_word),
        .ovr_flag  (ovr_flag)
    );

    spi_tx_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .half_tick (half_tick)
    );

    spi_tx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_full (hold_full),
        .hold_word (hold_word),
        .half_tick (half_tick),
        .take      (take),
        .run       (run),
        .busy      (busy),
        .sck       (sck),
        .mosi      (mosi)
    );

    assign tx_empty = ~hold_full;

endmodule

// File: rtl/spi_tx_dbuf_chk.sv
module spi_tx_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic ovr_clr,
    input logic tx_empty,
    input logic busy,
    input logic ovr_flag,
    input logic sck,
    input logic mosi
);

    // R2
    wr_empty_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_empty) |=> !tx_empty);

    // R3
    busy_rise_frees_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> tx_empty);

    // R7
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));

    // R8
    overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tx_empty) |=> ovr_flag);

    // R8
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !wr_en) |=> !ovr_flag);

    // R10
    sck_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> busy);

    // R10
    idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sck && !mosi));

endmodule

bind spi_tx_dbuf spi_tx_dbuf_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .ovr_clr  (ovr_clr),
    .tx_empty (tx_empty),
    .busy     (busy),
    .ovr_flag (ovr_flag),
    .sck      (sck),
    .mosi     (mosi)
);

// File: tb/spi_tx_dbuf_bench.sv
`timescale 1ns/1ps
module spi_tx_dbuf_bench;

    localparam int WORD_W  = 8;
    localparam int CLK_DIV = 32;
    localparam int NVEC    = 4;

    // Stimulus word and the word expected on mosi
    localparam logic [15:0] VEC [NVEC] = '{
        {8'hA5, 8'hA5},
        {8'h00, 8'h00},
        {8'hFF, 8'hFF},
        {8'h3C, 8'h3C}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              ovr_clr = 1'b0;
    logic              tx_empty, busy, ovr_flag, sck, mosi;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    int nbits = 0;
    logic [63:0] rxsh = '0;
    int edge_t [256];

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge sck) begin
        rxsh = {rxsh[62:0], mosi};
        edge_t[nbits % 256] = cyc;
        nbits = nbits + 1;
    end

    spi_tx_dbuf #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) u_spi_tx_dbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ovr_clr  (ovr_clr),
        .tx_empty (tx_empty),
        .busy     (busy),
        .ovr_flag (ovr_flag),
        .sck      (sck),
        .mosi     (mosi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [WORD_W-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail);
        $finish;
    end

    initial begin
        int base;
        int n;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 busy", busy, 0);
        chk("R1 sck", sck, 0);
        chk("R1 mosi", mosi, 0);
        chk("R1 ovr_flag", ovr_flag, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            base = nbits;
            wr(VEC[i][15:8]);
            chk("R2 tx_empty after write", tx_empty, 0);
            chk("R3 busy before take", busy, 0);
            @(negedge clk);
            chk("R3 tx_empty after take", tx_empty, 1);
            chk("R3 busy after take", busy, 1);
            wait_idle(n);
            chk("R4 busy length", n, 8 * CLK_DIV);
            chk("R5 bit count", nbits - base, 8);
            chk("R5 received word", rxsh[7:0], VEC[i][7:0]);
            chk("R6 sck period", edge_t[(base + 1) % 256] - edge_t[base % 256], CLK_DIV);
            chk("R10 idle sck", sck, 0);
            chk("R10 idle mosi", mosi, 0);
            repeat (5) @(negedge clk);
        end

        // Back-to-back with a dropped write
        base = nbits;
        wr(8'h96);
        @(negedge clk);
        wr(8'h4B);
        chk("R9 holding full while shifting", tx_empty, 0);
        chk("R8 no overrun yet", ovr_flag, 0);
        wr(8'hE7);
        chk("R8 overrun flag set", ovr_flag, 1);
        wait_idle(n);
        chk("R9 both words sent", nbits - base, 16);
        chk("R8 dropped word absent", rxsh[15:0], 16'h964B);
        chk("R9 no gap at word boundary", edge_t[(base + 8) % 256] - edge_t[(base + 7) % 256], CLK_DIV);
        chk("R8 holding empty after drop", tx_empty, 1);
        repeat (3) @(negedge clk);
        chk("R8 flag sticky", ovr_flag, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R8 flag cleared", ovr_flag, 0);

        // R8 set wins over clear in the same cycle
        wr(8'h11);
        @(negedge clk);
        wr(8'h22);
        ovr_clr = 1'b1;
        wr_en   = 1'b1;
        wr_data = 8'h33;
        @(negedge clk);
        wr_en   = 1'b0;
        ovr_clr = 1'b0;
        chk("R8 set beats clear", ovr_flag, 1);
        wait_idle(n);
        chk("R8 pair sent without dropped word", rxsh[15:0], 16'h1122);
        chk("R7 sck idles low", sck, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule